// File: doc/BRIEF.md
# PCI interrupt steering router

This block collects the four interrupt request pins of each of four add-in card slots and steers them onto a 16-bit vector of legacy IRQ requests. Each slot's pins first pass through a fixed rotation, so that the first pin of neighbouring slots lands on different shared lines. The slot pins that reach the same shared line are merged. Each of the four shared lines then goes through a routing register that either disables it or points it at one IRQ number from 0 to 15.

Software programs the four routing registers with single-byte configuration writes. The resulting IRQ request vector goes to a downstream interrupt controller. That controller is not part of this block, and neither are edge or level configuration and acknowledge cycles. Requests are active-high and level-sensitive. The output is registered, so it follows the pins and the registers with one clock of delay.

Top module: `irq_steer_router`

## Requirements
- R1: While `rst` is high, and after it is released with every routing register at its reset value of 0, `irq_req` is all zeros even when every slot pin is asserted.
- R2: A write with `cfg_wr_en` high to address 0xC0+n (n = 0..3, line 0 = INTA through line 3 = INTD) loads routing register n. Bit 7 of the data enables the line, and data bits [3:0] select the IRQ number that line drives.
- R3: When bit 7 of a line's routing register is clear, that line drives no `irq_req` bit, whatever its IRQ field holds.
- R4: Pin p of slot s drives `slot_int[4*s+p]`, with pins A..D as p = 0..3, and slots s = 0..3 standing for the card positions at device numbers 0x0B, 0x0D, 0x0F and 0x07. That pin feeds shared line (p+s) mod 4.
- R5: All slot pins that feed the same shared line are ORed, so any one of them requests that line's IRQ.
- R6: Shared lines routed to the same IRQ number are ORed into that single `irq_req` bit.
- R7: Writes to addresses outside 0xC0..0xC3 leave every route unchanged. Data bits [6:4] of a routing write have no effect.
- R8: `irq_req` is registered. A change on `slot_int` or in a routing register appears at the output one clock edge after it is sampled, and the output holds while neither changes.
- R9: Requests are level-sensitive. Removing the last pin that feeds a routed IRQ clears that bit on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| slot_int | input | 16 | Slot interrupt pins, bit 4*slot+pin, active high |
| irq_req | output | 16 | Registered legacy IRQ request vector |

## Verification
The hardest case to reach is the mapping of one slot pin through the rotation and a route to one exact IRQ bit. When many pins are asserted, a swapped rotation or a wrong decoder entry is hidden by the OR. The bench therefore enables a single line at a time, sweeps all sixteen IRQ numbers for it, and asserts one slot pin at a time. Each of the 1024 resulting combinations must light exactly the one predicted bit or none. Merging is then covered by pseudo-random full configurations, including several lines forced onto one IRQ.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

  localparam int unsigned ROUTE_BASE_DEFAULT = 32'h0000_00C0;
  localparam int unsigned ROUTE_EN_BIT       = 7;

  // Shared line reached by pin 'pin' of slot 'slot' under the rotation.
  function automatic int unsigned rot_line(input int unsigned slot,
                                           input int unsigned pin,
                                           input int unsigned nlines);
    return (slot + pin) % nlines;
  endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs #(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned IRQ_W     = 4,
  parameter int unsigned BASE      = irq_steer_pkg::ROUTE_BASE_DEFAULT,
  parameter int unsigned EN_BIT    = irq_steer_pkg::ROUTE_EN_BIT
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NUM_LINES-1:0]       route_en,
  output logic [NUM_LINES*IRQ_W-1:0] route_num
);

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE + n);
    logic hit;
    assign hit = wr_en && (addr == MY_ADDR);

    always_ff @(posedge clk) begin
      if (rst) begin
        route_en[n]                  <= 1'b0;
        route_num[n*IRQ_W +: IRQ_W]  <= '0;
      end else if (hit) begin
        route_en[n]                  <= wdata[EN_BIT];
        route_num[n*IRQ_W +: IRQ_W]  <= wdata[IRQ_W-1:0];
      end
    end
  end

endmodule

// File: rtl/irq_pin_swizzle.sv
module irq_pin_swizzle #(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned NUM_PINS  = 4,
  parameter int unsigned NUM_LINES = 4
) (
  input  logic [NUM_SLOTS*NUM_PINS-1:0] slot_pins,
  output logic [NUM_LINES-1:0]          line_lvl
);

  import irq_steer_pkg::*;

  always_comb begin
    line_lvl = '0;
    for (int unsigned s = 0; s < NUM_SLOTS; s++) begin
      for (int unsigned p = 0; p < NUM_PINS; p++) begin
        line_lvl[rot_line(s, p, NUM_LINES)] =
          line_lvl[rot_line(s, p, NUM_LINES)] | slot_pins[s*NUM_PINS + p];
      end
    end
  end

endmodule

// File: rtl/irq_line_steer.sv
module irq_line_steer #(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned NUM_IRQS  = 16,
  parameter int unsigned IRQ_W     = $clog2(NUM_IRQS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_LINES-1:0]       line_lvl,
  input  logic [NUM_LINES-1:0]       route_en,
  input  logic [NUM_LINES*IRQ_W-1:0] route_num,
  output logic [NUM_IRQS-1:0]        irq_req
);

  logic [NUM_LINES-1:0][NUM_IRQS-1:0] line_vec;
  logic [NUM_IRQS-1:0]                merged;

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_dec
    logic [IRQ_W-1:0] sel;
    assign sel = route_num[n*IRQ_W +: IRQ_W];
    always_comb begin
      line_vec[n] = '0;
      for (int unsigned q = 0; q < NUM_IRQS; q++) begin
        line_vec[n][q] = line_lvl[n] && route_en[n] && (sel == IRQ_W'(q));
      end
    end
  end

  always_comb begin
    merged = '0;
    for (int unsigned n = 0; n < NUM_LINES; n++) begin
      merged = merged | line_vec[n];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_req <= '0;
    else     irq_req <= merged;
  end

endmodule

// File: rtl/irq_steer_router.sv
module irq_steer_router #(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned NUM_PINS  = 4,
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned NUM_IRQS  = 16,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BASE      = irq_steer_pkg::ROUTE_BASE_DEFAULT
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_wr_en,
  input  logic [ADDR_W-1:0]             cfg_addr,
  input  logic [DATA_W-1:0]             cfg_wdata,
  input  logic [NUM_SLOTS*NUM_PINS-1:0] slot_int,
  output logic [NUM_IRQS-1:0]           irq_req
);

  localparam int unsigned IRQ_W = $clog2(NUM_IRQS);

  logic [NUM_LINES-1:0]       route_en;
  logic [NUM_LINES*IRQ_W-1:0] route_num;
  logic [NUM_LINES-1:0]       line_lvl;

  irq_route_regs #(
    .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .IRQ_W(IRQ_W), .BASE(BASE), .EN_BIT(irq_steer_pkg::ROUTE_EN_BIT)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .addr(cfg_addr),
    .wdata(cfg_wdata), .route_en(route_en), .route_num(route_num)
  );

  irq_pin_swizzle #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_PINS(NUM_PINS), .NUM_LINES(NUM_LINES)
  ) u_swz (
    .slot_pins(slot_int), .line_lvl(line_lvl)
  );

  irq_line_steer #(
    .NUM_LINES(NUM_LINES), .NUM_IRQS(NUM_IRQS), .IRQ_W(IRQ_W)
  ) u_steer (
    .clk(clk), .rst(rst), .line_lvl(line_lvl), .route_en(route_en),
    .route_num(route_num), .irq_req(irq_req)
  );

endmodule

// File: rtl/irq_steer_router_chk.sv
module irq_steer_router_chk #(
  parameter int unsigned SLOT_BITS = 16,
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned NUM_IRQS  = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cfg_wr_en,
  input logic [SLOT_BITS-1:0] slot_int,
  input logic [NUM_LINES-1:0] line_lvl,
  input logic [NUM_IRQS-1:0]  irq_req
);

  // R1: the first cycle after reset shows a cleared vector
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_req == '0));

  // R3: with no pin asserted, no IRQ can be requested one edge later
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(slot_int) == '0) |-> (irq_req == '0));

  // R5: merging never creates more active lines than active pins
  p_lines_bounded_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(line_lvl) <= $countones(slot_int));

  // R6: at most one IRQ bit per shared line
  p_irq_bounded_r6: assert property (@(posedge clk) disable iff (rst)
    $countones(irq_req) <= NUM_LINES);

  // R8: steady pins and no write keep the output steady
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    ($stable(slot_int) && !$past(cfg_wr_en)) |=> $stable(irq_req));

endmodule

bind irq_steer_router irq_steer_router_chk u_chk (
  .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .slot_int(slot_int),
  .line_lvl(line_lvl), .irq_req(irq_req)
);

// File: tb/tb_irq_steer_router.sv
`timescale 1ns/1ps
module tb_irq_steer_router;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [15:0] slot_int = '0;
  logic [15:0] irq_req;

  int tests = 0;
  int fails = 0;
  logic [3:0][7:0] shadow;
  logic [31:0] seed = 32'h1234_abcd;

  always #4 clk = ~clk;

  irq_steer_router dut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .slot_int(slot_int), .irq_req(irq_req)
  );

  function automatic logic [15:0] expect_irq(input logic [15:0] pins,
                                              input logic [3:0][7:0] cfg);
    logic [3:0]  ln;
    logic [15:0] r;
    ln = '0;
    r  = '0;
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 4; p++)
        if (pins[s*4+p]) ln[(s+p)%4] = 1'b1;
    for (int n = 0; n < 4; n++)
      if (ln[n] && cfg[n][7]) r[cfg[n][3:0]] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] next_rand(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic check(input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: irq_req=%h expected=%h", req, act, exp);
    end
  endtask

  // Issues a write; returns at the negedge after the register edge.
  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    if (a >= 8'hC0 && a <= 8'hC3) shadow[a-8'hC0] = d;
  endtask

  // Applies pins at a negedge; result visible at the following negedge.
  task automatic apply_pins(input logic [15:0] pins);
    slot_int = pins;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: irq_req=%h expected=done", irq_req);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    shadow   = '0;
    slot_int = 16'hFFFF;
    repeat (4) @(negedge clk);
    check("R1 in reset", irq_req, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 after reset", irq_req, 16'h0000);

    // R4 and R2: one line enabled, every IRQ number, single pins
    for (int n = 0; n < 4; n++) begin
      for (int q = 0; q < 16; q++) begin
        cfg_write(8'hC0 + 8'(n), 8'h80 | 8'(q));
        for (int b = 0; b < 16; b++) begin
          apply_pins(16'h1 << b);
          check("R4 R2 sweep", irq_req, expect_irq(16'h1 << b, shadow));
        end
      end
      cfg_write(8'hC0 + 8'(n), 8'h00);
    end

    // R3: disabled lines with IRQ fields set drive nothing
    for (int n = 0; n < 4; n++) cfg_write(8'hC0 + 8'(n), 8'h7A);
    apply_pins(16'hFFFF);
    check("R3 disabled", irq_req, 16'h0000);

    // R7: writes outside the window change nothing
    cfg_write(8'hBF, 8'h85);
    cfg_write(8'hC4, 8'h86);
    cfg_write(8'h40, 8'h87);
    apply_pins(16'hFFFF);
    check("R7 outside window", irq_req, 16'h0000);

    // R7: bits 6:4 ignored
    cfg_write(8'hC0, 8'hF3);
    apply_pins(16'h0001);
    check("R7 reserved bits", irq_req, 16'h0008);

    // R5: every pin feeding line 0 alone requests IRQ3
    apply_pins(16'h0000);
    apply_pins(16'b0010_0100_1000_0001);
    check("R5 all of line0", irq_req, 16'h0008);
    apply_pins(16'b0010_0000_0000_0000);
    check("R5 slot3 pinB", irq_req, 16'h0008);

    // R6: all lines onto IRQ 9
    for (int n = 0; n < 4; n++) cfg_write(8'hC0 + 8'(n), 8'h89);
    apply_pins(16'hFFFF);
    check("R6 merged", irq_req, 16'h0200);
    apply_pins(16'h0100);
    check("R6 single", irq_req, 16'h0200);

    // R9: level release
    apply_pins(16'h0000);
    check("R9 release", irq_req, 16'h0000);

    // R8: one-edge latency
    cfg_write(8'hC1, 8'h8E);
    slot_int = 16'h0002;
    #2;
    check("R8 before edge", irq_req, 16'h0000);
    @(negedge clk);
    check("R8 after edge", irq_req, 16'h4000);
    @(negedge clk);
    check("R8 hold", irq_req, 16'h4000);

    // R5 R6 pseudo-random full configurations
    for (int k = 0; k < 300; k++) begin
      seed = next_rand(seed);
      if (k % 10 == 0) begin
        for (int n = 0; n < 4; n++) begin
          seed = next_rand(seed);
          cfg_write(8'hC0 + 8'(n), seed[7:0]);
        end
      end
      seed = next_rand(seed);
      apply_pins(seed[15:0] & seed[31:16]);
      check("R5 R6 random", irq_req, expect_irq(slot_int, shadow));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule